// File: doc/BRIEF.md
# Logic Sample Capture and Packer

This block is the front end of a multi-channel logic capture path. It brings a 16-bit bank of asynchronous pins into the clock domain, samples them at an integer fraction of the core clock, and packs consecutive samples into 32-byte chunks. Each completed chunk is handed to a downstream writer in a single cycle with a valid strobe and a running byte total.

Software arms a capture with a one-cycle start pulse. The pulse also loads the divider N and the sample width (one byte holding pins 7..0, or two bytes holding all 16 pins). Capture runs until a one-cycle stop pulse. The sampling cadence never waits on the consumer: a completed chunk is copied into a holding register, and the next chunk begins filling in the same cycle. The consumer uses the byte total that comes with each chunk to detect chunks it missed.

Top module: `logic_capture_packer`

## Requirements
- R1: While reset is asserted, and until the first chunk completes, `chunk_vld_o` is 0, `byte_cnt_o` is 0 and `chunk_o` is all zeros.
- R2: The first sample is taken at the clock edge after the edge that registers `start_i`. Further samples follow every N edges, where N is `div_i` captured at start. A `div_i` of 0 is treated as 1.
- R3: The value stored for a sample taken at edge t is the value `pins_i` had at edge t-2. This is the latency of the two-stage synchroniser.
- R4: In narrow mode (`wide_i`=0 at start), sample k of a chunk (k = 0..31) stores `pins_i[7:0]` at `chunk_o[8k+7:8k]`. Lane 0 is the least significant byte, and 32 samples complete one chunk.
- R5: In wide mode (`wide_i`=1 at start), sample k of a chunk (k = 0..15) stores all 16 pins at `chunk_o[16k+15:16k]`, and 16 samples complete one chunk.
- R6: `chunk_vld_o` is high for exactly one cycle, starting just after the edge that takes the last sample of a chunk. `chunk_o` changes only in a cycle where `chunk_vld_o` is high, and holds its value otherwise.
- R7: The sample cadence has no gap across a chunk handoff. The first sample of the next chunk is taken N edges after the last sample of the previous chunk.
- R8: A start pulse clears the byte total. Each chunk adds 32, and the new total appears on `byte_cnt_o` in the same cycle as `chunk_vld_o`.
- R9: A stop pulse ends capture and discards any partial chunk. No strobe is raised for it, and `chunk_o` and `byte_cnt_o` keep their values. If start and stop arrive together, stop wins and the start has no effect.
- R10: Changes to `div_i` or `wide_i` while a capture runs have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the sample rate is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 16 | Asynchronous logic inputs to be captured |
| div_i | input | 16 | Rate divider N, loaded at start |
| wide_i | input | 1 | Sample width, loaded at start: 0 = one byte, 1 = two bytes |
| start_i | input | 1 | One-cycle pulse that begins a capture |
| stop_i | input | 1 | One-cycle pulse that ends a capture |
| chunk_o | output | 256 | Last completed 32-byte chunk |
| chunk_vld_o | output | 1 | One-cycle strobe marking a new chunk |
| byte_cnt_o | output | 32 | Running byte total since start, sent with each chunk |

## Verification
The hardest situation to reach is one where a capture has already delivered chunks and is then stopped partway through the next one. At that point the held chunk, the byte total and the missing strobe all have to be checked together. The stimulus reaches it by letting a full chunk complete without stopping, feeding ten more samples, and then pulsing stop. A simultaneous start and stop follows, to show that nothing is cleared. Every pin value is a known function of the edge number, and the packing stage is the only place these values are rearranged. Comparing whole chunks against that function therefore checks synchroniser latency, lane order and the continuous cadence across handoffs, at several divider settings and in both widths.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
    localparam int LANE_W      = 8;
    localparam int PIN_W       = 2 * LANE_W;
    localparam int CHUNK_BYTES = 32;
    localparam int CHUNK_W     = CHUNK_BYTES * LANE_W;
    localparam int PTR_W       = $clog2(CHUNK_BYTES);

    typedef enum logic {
        SMP_NARROW = 1'b0,
        SMP_WIDE   = 1'b1
    } smp_width_e;
endpackage

// File: rtl/lcp_sync.sv
module lcp_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_comb stg_d[i] = din;
        end else begin : g_next
            always_comb stg_d[i] = stg_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/lcp_pacer.sv
module lcp_pacer
    import lcp_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             wide_i,
    output logic             tick_o,
    output smp_width_e       mode_o
);
    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
        smp_width_e       mode;
    } pacer_t;

    pacer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_i) begin
            st_d.run = 1'b0;
        end else if (start_i) begin
            st_d.run  = 1'b1;
            st_d.div  = (div_i == '0) ? DIV_W'(1) : div_i;
            st_d.cnt  = '0;
            st_d.mode = smp_width_e'(wide_i);
        end else if (st_q.run) begin
            st_d.cnt = (st_q.cnt == st_q.div - 1'b1) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: 1'b0, div: DIV_W'(1), cnt: '0, mode: SMP_NARROW};
        else        st_q <= st_d;
    end

    assign tick_o = st_q.run && (st_q.cnt == '0);
    assign mode_o = st_q.mode;

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && st_q.div != DIV_W'(1) && !start_i) |=> !tick_o);

    // R9
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !tick_o);
endmodule

// File: rtl/lcp_packer.sv
module lcp_packer
    import lcp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               tick_i,
    input  smp_width_e         mode_i,
    input  logic [PIN_W-1:0]   sample_i,
    output logic [CHUNK_W-1:0] chunk_o,
    output logic               vld_o,
    output logic [CNT_W-1:0]   cnt_o
);
    typedef struct packed {
        logic [CHUNK_W-1:0] fill;
        logic [PTR_W-1:0]   pos;
        logic [CHUNK_W-1:0] hold;
        logic               vld;
        logic [CNT_W-1:0]   cnt;
    } pack_t;

    pack_t              st_d, st_q;
    logic [CHUNK_W-1:0] merged;
    int                 step;

    always_comb begin
        merged = st_q.fill;
        step   = (mode_i == SMP_WIDE) ? 2 : 1;
        for (int l = 0; l < CHUNK_BYTES; l++) begin
            if (l == int'(st_q.pos))
                merged[l*LANE_W +: LANE_W] = sample_i[LANE_W-1:0];
            if (mode_i == SMP_WIDE && l == int'(st_q.pos) + 1)
                merged[l*LANE_W +: LANE_W] = sample_i[PIN_W-1:LANE_W];
        end

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (stop_i) begin
            st_d.pos = '0;
        end else if (start_i) begin
            st_d.pos = '0;
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.fill = merged;
            if (int'(st_q.pos) + step == CHUNK_BYTES) begin
                st_d.hold = merged;
                st_d.vld  = 1'b1;
                st_d.cnt  = st_q.cnt + CNT_W'(CHUNK_BYTES);
                st_d.pos  = '0;
            end else begin
                st_d.pos = st_q.pos + PTR_W'(step);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chunk_o = st_q.hold;
    assign vld_o   = st_q.vld;
    assign cnt_o   = st_q.cnt;

    // R6
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> $stable(chunk_o));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> cnt_o == $past(cnt_o) + CNT_W'(CHUNK_BYTES));

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> cnt_o == '0);

    // R9
    stop_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !vld_o);
endmodule

// File: rtl/logic_capture_packer.sv
module logic_capture_packer #(
    parameter int DIV_W       = 16,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      pins_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             wide_i,
    input  logic             start_i,
    input  logic             stop_i,
    output logic [255:0]     chunk_o,
    output logic             chunk_vld_o,
    output logic [CNT_W-1:0] byte_cnt_o
);
    import lcp_pkg::*;

    logic [PIN_W-1:0] pins_s;
    logic             tick;
    smp_width_e       mode;

    lcp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_i),
        .dout (pins_s)
    );

    lcp_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .stop_i (stop_i),
        .div_i  (div_i),
        .wide_i (wide_i),
        .tick_o (tick),
        .mode_o (mode)
    );

    lcp_packer #(.CNT_W(CNT_W)) u_packer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .stop_i  (stop_i),
        .tick_i  (tick),
        .mode_i  (mode),
        .sample_i(pins_s),
        .chunk_o (chunk_o),
        .vld_o   (chunk_vld_o),
        .cnt_o   (byte_cnt_o)
    );
endmodule

// File: tb/logic_capture_packer_bench.sv
module logic_capture_packer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  pins_i;
    logic [15:0]  div_i = 16'd1;
    logic         wide_i = 1'b0;
    logic         start_i = 1'b0;
    logic         stop_i = 1'b0;
    logic [255:0] chunk_o;
    logic         chunk_vld_o;
    logic [31:0]  byte_cnt_o;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;
    logic [255:0] last_chunk;

    always #10 clk = ~clk;

    logic_capture_packer u_logic_capture_packer (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .div_i(div_i),
        .wide_i(wide_i), .start_i(start_i), .stop_i(stop_i),
        .chunk_o(chunk_o), .chunk_vld_o(chunk_vld_o), .byte_cnt_o(byte_cnt_o)
    );

    function automatic logic [15:0] pat(int c);
        return 16'((c * 40503 + 7) ^ (c >>> 5));
    endfunction

    always @(posedge clk) ecnt <= ecnt + 1;
    initial pins_i = pat(1);
    always @(negedge clk) pins_i <= pat(ecnt + 1);

    task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        int n;
        bit w;
        int nch;
        bit tog;
    } cfg_t;

    localparam cfg_t TBL [6] = '{
        '{1, 1'b0, 2, 1'b0},
        '{1, 1'b1, 2, 1'b0},
        '{3, 1'b0, 1, 1'b0},
        '{2, 1'b1, 2, 1'b1},
        '{5, 1'b1, 1, 1'b0},
        '{0, 1'b0, 1, 1'b1}
    };

    task automatic run_cfg(cfg_t c, bit do_stop);
        int s, neff, spc, last;
        bit early;
        logic [255:0] exp;
        @(negedge clk);
        div_i = 16'(c.n); wide_i = c.w; start_i = 1'b1;
        s = ecnt + 1;
        @(negedge clk);
        start_i = 1'b0;
        if (c.tog) begin
            // R10: alter settings while running
            wide_i = ~c.w;
            div_i  = 16'd7;
        end
        neff = (c.n == 0) ? 1 : c.n;
        spc  = c.w ? 16 : 32;
        for (int j = 0; j < c.nch; j++) begin
            last  = s + 1 + ((j + 1) * spc - 1) * neff;
            early = 1'b0;
            while (ecnt < last) begin
                if (chunk_vld_o) early = 1'b1;
                @(negedge clk);
            end
            chk(!early, "R6 no strobe before chunk completes", 256'(early), 256'(0));
            chk(chunk_vld_o == 1'b1, "R2/R7 strobe at cadence edge", 256'(chunk_vld_o), 256'(1));
            exp = '0;
            for (int k = 0; k < spc; k++) begin
                int t;
                t = s + 1 + (j * spc + k) * neff;
                if (c.w) exp[16*k +: 16] = pat(t - 2);
                else     exp[8*k +: 8]   = pat(t - 2) & 16'h00ff;
            end
            chk(chunk_o == exp, c.w ? "R5/R3/R7/R10 wide chunk data" : "R4/R3/R7/R10 narrow chunk data",
                chunk_o, exp);
            chk(byte_cnt_o == 32'(32 * (j + 1)), "R8 byte total", 256'(byte_cnt_o), 256'(32 * (j + 1)));
            last_chunk = chunk_o;
            @(negedge clk);
            chk(chunk_vld_o == 1'b0, "R6 strobe lasts one cycle", 256'(chunk_vld_o), 256'(0));
        end
        if (do_stop) begin
            stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        logic [31:0] held_cnt;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(chunk_vld_o == 1'b0, "R1 strobe in reset", 256'(chunk_vld_o), 256'(0));
        chk(byte_cnt_o == 32'd0, "R1 total in reset", 256'(byte_cnt_o), 256'(0));
        chk(chunk_o == '0, "R1 chunk in reset", chunk_o, 256'(0));
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(chunk_vld_o == 1'b0 && byte_cnt_o == 0, "R1 idle after reset", 256'(byte_cnt_o), 256'(0));

        foreach (TBL[i]) run_cfg(TBL[i], 1'b1);

        // R9: stop partway through a second chunk
        run_cfg('{1, 1'b0, 1, 1'b0}, 1'b0);
        repeat (10) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        seen = 1'b0;
        repeat (60) begin
            if (chunk_vld_o) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R9 no strobe for partial chunk", 256'(seen), 256'(0));
        chk(byte_cnt_o == 32'd32, "R9 total kept after stop", 256'(byte_cnt_o), 256'(32));
        chk(chunk_o == last_chunk, "R9 chunk kept after stop", chunk_o, last_chunk);

        // R9: start and stop together, stop wins
        held_cnt = byte_cnt_o;
        div_i = 16'd1; wide_i = 1'b0;
        start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        seen = 1'b0;
        repeat (70) begin
            if (chunk_vld_o) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R9 simultaneous start/stop does not run", 256'(seen), 256'(0));
        chk(byte_cnt_o == held_cnt, "R9 simultaneous start/stop keeps total", 256'(byte_cnt_o), 256'(held_cnt));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule